// File: doc/BRIEF.md
# Joypad Matrix Scan Register

This block is the joypad port register of a small handheld console. Software writes a byte whose two select bits pick which half of an eight-key matrix it wants to look at: the four direction keys, the four action buttons, both halves merged, or neither. When neither half is selected, the port reports the index of the controller currently addressed, which is used when several pads share the port. The block returns a byte in which each selected key reads 0 while it is pressed. It also emits a keypad interrupt request whenever any of the four result lines goes from 1 to 0.

The low four bits of the read value are a registered result. It is recomputed on every clock edge from the stored select bits, the key-pressed vector and the controller index. A change at the inputs therefore shows up, and can raise the interrupt, without any software access. The interrupt output is a one-cycle pulse meant to be ORed into an interrupt-flag register that lives elsewhere. Debouncing of the key inputs is handled outside this block.

Top module: `jpad_port`

## Requirements
- R1: With select bits [5:4] = 2'b10, result bits [3:0] are the inverse of key bits [7:4], so a pressed key (input 1) reads 0.
- R2: With select bits = 2'b01, result bits [3:0] are the inverse of key bits [3:0]; key bits [7:4] have no effect.
- R3: With select bits = 2'b00, result bit i is the inverse of (key[i] OR key[i+4]).
- R4: With select bits = 2'b11, result bits [3:0] are the inverse of the controller index, zero-extended to four bits; the keys have no effect.
- R5: While the controller index is nonzero, the key vector is treated as all released, so with select 2'b00, 2'b01 or 2'b10 the result reads 4'b1111.
- R6: The read byte is {2'b11, select[1:0], result[3:0]}: bits 7:6 always read 1.
- R7: A write stores only bits [5:4] of the written byte. The other bits are ignored. The result for the new selection is visible in the cycle after the write edge.
- R8: The interrupt output pulses high for exactly one cycle after an edge at which any result bit went from 1 to 0. For an edge that takes a write, the previous result is taken as 4'b1111, so a write that selects a held key raises the interrupt.
- R9: The result follows changes in the key vector and the controller index with no write. A result bit going from 0 to 1 (key release) raises no interrupt, and a key held steady raises no further pulse.
- R10: During and right after reset, the select bits are 2'b11, the result is 4'b1111 (read byte 0xFF) and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the port byte |
| wr_data | input | 8 | Written byte; only bits [5:4] are kept |
| rd_data | output | 8 | Read byte {2'b11, select, result} |
| keys_pressed | input | 8 | Key matrix, 1 = pressed; [3:0] one group, [7:4] the other |
| pad_index | input | 2 | Index of the controller currently addressed |
| kpad_irq | output | 1 | One-cycle keypad interrupt request pulse |

## Verification
Each select code is tried with key patterns that differ between the two halves, for example only upper keys or only lower keys pressed. A wrong half, or a missing OR in merged mode, then gives a distinct nibble. The controller-index mode is driven with all keys pressed and index 0, then with index 2, which separates index readback from key readback. A nonzero index with upper keys pressed checks the all-released gating. Interrupt tests compare pressing against releasing, a second key added while one is held, a key held over several cycles, and a write that selects a key already held. Together they separate falling-edge detection from level or any-change detection.

// File: rtl/jpad_pkg.sv
package jpad_pkg;

  // Encoding of the two active-low group select bits
  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_ID   = 2'b11
  } grp_sel_e;

endpackage

// File: rtl/jpad_key_gate.sv
// Forces the key matrix to "all released" while a nonzero controller is addressed.
module jpad_key_gate #(
  parameter int KEY_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [KEY_W-1:0] keys_in,
  input  logic [IDX_W-1:0] idx,
  output logic [KEY_W-1:0] keys_out
);

  logic idx_nonzero;

  always_comb begin
    idx_nonzero = (idx != '0);
    keys_out    = idx_nonzero ? '0 : keys_in;
  end

endmodule

// File: rtl/jpad_group_mux.sv
// Picks the active-high nibble chosen by the select code.
module jpad_group_mux
  import jpad_pkg::*;
#(
  parameter int GROUP_W = 4,
  parameter int IDX_W   = 2
) (
  input  grp_sel_e                 sel,
  input  logic [2*GROUP_W-1:0]     keys,
  input  logic [IDX_W-1:0]         idx,
  output logic [GROUP_W-1:0]       picked
);

  logic [GROUP_W-1:0] lo_grp;
  logic [GROUP_W-1:0] hi_grp;
  logic [GROUP_W-1:0] idx_ext;
  logic [GROUP_W-1:0] merged;

  assign lo_grp = keys[GROUP_W-1:0];
  assign hi_grp = keys[2*GROUP_W-1:GROUP_W];

  // Bitwise merge of the two halves, one OR gate per line
  genvar g;
  generate
    for (g = 0; g < GROUP_W; g++) begin : g_merge
      assign merged[g] = lo_grp[g] | hi_grp[g];
    end
  endgenerate

  always_comb begin
    idx_ext = '0;
    idx_ext[IDX_W-1:0] = idx;
  end

  always_comb begin
    unique case (sel)
      SEL_HIGH: picked = hi_grp;
      SEL_LOW:  picked = lo_grp;
      SEL_BOTH: picked = merged;
      SEL_ID:   picked = idx_ext;
      default:  picked = '0;
    endcase
  end

endmodule

// File: rtl/jpad_fall_detect.sv
// Registers a one-cycle pulse when any line goes from 1 to 0.
module jpad_fall_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] before_v,
  input  logic [W-1:0] after_v,
  output logic         pulse
);

  logic [W-1:0] fell;
  logic         pulse_d;
  logic         pulse_q;

  always_comb begin
    fell    = before_v & ~after_v;
    pulse_d = |fell;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/jpad_port.sv
// Joypad port register: group select, registered result nibble, fall interrupt.
module jpad_port
  import jpad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] keys_pressed,
  input  logic [IDX_W-1:0]  pad_index,
  output logic              kpad_irq
);

  localparam int GROUP_W = DATA_W / 2;
  localparam int SEL_LSB = GROUP_W;
  localparam int SEL_MSB = GROUP_W + 1;
  localparam int TOP_W   = DATA_W - GROUP_W - 2;

  grp_sel_e           sel_q;
  grp_sel_e           sel_d;
  logic               sel_en;
  logic [GROUP_W-1:0] res_q;
  logic [GROUP_W-1:0] res_d;
  logic [GROUP_W-1:0] res_before;
  logic [GROUP_W-1:0] picked;
  logic [DATA_W-1:0]  keys_gated;
  logic [GROUP_W-1:0] idx_view;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DATA_W-1:SEL_MSB+1], wr_data[SEL_LSB-1:0]};

  jpad_key_gate #(
    .KEY_W (DATA_W),
    .IDX_W (IDX_W)
  ) i_gate (
    .keys_in  (keys_pressed),
    .idx      (pad_index),
    .keys_out (keys_gated)
  );

  jpad_group_mux #(
    .GROUP_W (GROUP_W),
    .IDX_W   (IDX_W)
  ) i_mux (
    .sel    (sel_d),
    .keys   (keys_gated),
    .idx    (pad_index),
    .picked (picked)
  );

  // Next-state: a write takes effect in the same edge's result computation
  always_comb begin
    sel_en     = wr_en;
    sel_d      = sel_en ? grp_sel_e'(wr_data[SEL_MSB:SEL_LSB]) : sel_q;
    res_d      = ~picked;
    res_before = sel_en ? {GROUP_W{1'b1}} : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_ID;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= {GROUP_W{1'b1}};
    end else begin
      res_q <= res_d;
    end
  end

  jpad_fall_detect #(
    .W (GROUP_W)
  ) i_fall (
    .clk      (clk),
    .rst_n    (rst_n),
    .before_v (res_before),
    .after_v  (res_d),
    .pulse    (kpad_irq)
  );

  assign rd_data = {{TOP_W{1'b1}}, sel_q, res_q};

  always_comb begin
    idx_view = '0;
    idx_view[IDX_W-1:0] = pad_index;
  end

  // R7
  sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[SEL_MSB:SEL_LSB] == $past(wr_data[SEL_MSB:SEL_LSB])));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kpad_irq |-> ($past(wr_en) || (($past(rd_data[GROUP_W-1:0]) & ~rd_data[GROUP_W-1:0]) != '0)));

  // R5
  idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sel_q != SEL_ID && pad_index != '0) |=> (rd_data[GROUP_W-1:0] == {GROUP_W{1'b1}}));

  // R4
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sel_q == SEL_ID) |=> (rd_data[GROUP_W-1:0] == ~$past(idx_view)));

  // R9
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ((res_q & ~res_d) == '0)) |=> !kpad_irq);

endmodule

// File: tb/test_jpad_port.sv
module test_jpad_port;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] keys_pressed;
  logic [1:0] pad_index;
  logic       kpad_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  jpad_port i_jpad_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .keys_pressed (keys_pressed),
    .pad_index    (pad_index),
    .kpad_irq     (kpad_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {written byte, keys, index, expected read byte, expected irq}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {8'h20, 8'h50, 8'h00, 8'hEA, 1'b1},  // R1 upper half
    {8'h10, 8'h50, 8'h00, 8'hDF, 1'b0},  // R2 upper keys ignored
    {8'h10, 8'h03, 8'h00, 8'hDC, 1'b1},  // R2 lower half
    {8'h00, 8'h12, 8'h00, 8'hCC, 1'b1},  // R3 merged
    {8'h00, 8'h84, 8'h00, 8'hC3, 1'b1},  // R3 merged, other lines
    {8'h30, 8'hFF, 8'h00, 8'hFF, 1'b0},  // R4 index 0, keys ignored
    {8'h30, 8'h00, 8'h02, 8'hFD, 1'b1},  // R4 index 2
    {8'h20, 8'hF0, 8'h01, 8'hEF, 1'b0},  // R5 nonzero index gates keys
    {8'h2F, 8'h00, 8'h00, 8'hEF, 1'b0},  // R7 low nibble of write ignored
    {8'hC0, 8'h00, 8'h00, 8'hCF, 1'b0}   // R6/R7 top bits ignored
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rd_data act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s kpad_irq act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] b);
    wr_en   = 1'b1;
    wr_data = b;
    step();
    wr_en   = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; keys_pressed = 8'h00; pad_index = 2'd0;
    repeat (3) @(negedge clk);
    check8("R10", rd_data, 8'hFF);
    check1("R10", kpad_irq, 1'b0);
    rst_n = 1'b1;
    step();
    check8("R10", rd_data, 8'hFF);
    check1("R10", kpad_irq, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      keys_pressed = 8'h00;
      pad_index    = 2'd0;
      do_write(VEC[v][32:25]);
      check1("R8 quiet write", kpad_irq, 1'b0);
      keys_pressed = VEC[v][24:17];
      pad_index    = VEC[v][10:9];
      step();
      check8("R1-table", rd_data, VEC[v][8:1]);
      check1("R8-table", kpad_irq, VEC[v][0]);
    end

    // R8: write selecting an already held key raises the interrupt
    keys_pressed = 8'h00; pad_index = 2'd0;
    do_write(8'h30);
    keys_pressed = 8'h01;
    step();
    check1("R9 id mode ignores keys", kpad_irq, 1'b0);
    do_write(8'h10);
    check8("R8", rd_data, 8'hDE);
    check1("R8 write on held key", kpad_irq, 1'b1);
    step();
    check1("R8 single pulse", kpad_irq, 1'b0);
    step();
    check1("R9 held key no repeat", kpad_irq, 1'b0);

    // R9: add a second key while one held
    keys_pressed = 8'h03;
    step();
    check8("R9", rd_data, 8'hDC);
    check1("R9 added key", kpad_irq, 1'b1);
    // R9: release gives no interrupt
    keys_pressed = 8'h00;
    step();
    check8("R9", rd_data, 8'hDF);
    check1("R9 release quiet", kpad_irq, 1'b0);

    // R10: reset in mid-run
    keys_pressed = 8'h0F;
    step();
    rst_n = 1'b0;
    #1;
    check8("R10 async", rd_data, 8'hFF);
    check1("R10 async", kpad_irq, 1'b0);
    keys_pressed = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check8("R10 after", rd_data, 8'hFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule